// File: doc/BRIEF.md
# Bank Command State Machine

This block follows one DRAM bank through its open, closed and in-flight conditions and works out the single command that bank would like to put on the shared command bus next. It pulls one pending request (row, read or write, tag) at a time from a request source. It then proposes an activate, precharge, read or write, once a delay reported by an external timing checker has run out. A memory-side completion pulse closes each in-flight command. When a read or write completes, the tag of the request is handed back.

A bank arbiter sits above several copies of this block. It grants at most one candidate per cycle. It also tells every copy when any command went out on the bus, so that banks that lost the cycle re-time their offer. Timing arithmetic, arbitration and the data path live elsewhere.

Top module: `bank_cmd_fsm`

## Requirements
- R1: After reset the bank is closed (precharged), holds no request, offers no candidate (`cand_valid`=0, `cand_cmd`=0 meaning NOP), and `result_valid` and `proto_err` are 0.
- R2: `req_take` is high in exactly the cycles where no request is held and `req_valid` is high. The request fields are captured at that edge. While a request is held, `req_valid` is ignored.
- R3: In the closed state with a request held, the candidate is ACT (`cand_cmd`=1). When ACT is granted, the request's row becomes the open row and the bank enters the activating state.
- R4: In the open state, a request whose row equals the open row gives RD (`cand_cmd`=3) when `req_write` was 0 or WR (`cand_cmd`=4) when it was 1. A different row gives PRE (`cand_cmd`=2).
- R5: Evaluation happens in any cycle where the bank is closed or open, holds a request and has no candidate pending. The candidate becomes visible max(0, `chk_delay`)+1 cycles after that evaluation cycle, and the output is NOP before then.
- R6: A visible candidate stays unchanged until `grant` is high in a cycle where it is visible. The grant clears it and moves the bank to activating, precharging, reading or writing for ACT, PRE, RD or WR.
- R7: When `cmd_sent` is high with a visible candidate that is not granted, the candidate is withdrawn. It reappears max(1, `chk_delay`)+1 cycles after that cycle.
- R8: A completion pulse moves activating to open and precharging to closed, with no result.
- R9: A completion pulse in reading or writing moves the bank to open. `result_valid` is then high for exactly one cycle, with `result_id` equal to the request's tag, and the request is released so that a new one can be taken.
- R10: A completion pulse while the bank is closed or open sets `proto_err`, which stays set until reset. The bank state is left unchanged.
- R11: `grant` has no effect in a cycle where no candidate is visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request source has a request for this bank |
| req_row | input | ROW_W | Row of the offered request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_id | input | ID_W | Tag of the offered request |
| req_take | output | 1 | Request is captured at this edge |
| chk_delay | input | DLY_W | Cycles the timing checker still requires |
| grant | input | 1 | Arbiter accepts this bank's candidate |
| cmd_sent | input | 1 | Some command went out on the bus this cycle |
| done_pulse | input | 1 | Memory side reports the in-flight command finished |
| cand_valid | output | 1 | A candidate is offered |
| cand_cmd | output | 3 | Candidate: 0 NOP, 1 ACT, 2 PRE, 3 RD, 4 WR |
| result_valid | output | 1 | A read or write has completed |
| result_id | output | ID_W | Tag of the completed request |
| proto_err | output | 1 | Sticky flag for a completion in a settled state |

## Verification
The hardest situation to reach from the ports is a candidate withdrawn by another bank's command and then re-timed with the one-cycle floor. Without a second bank, this needs a candidate that is visible but not granted while `cmd_sent` is pulsed by hand. The bench parks a precharge candidate, pulses `cmd_sent` with a fresh checker delay, and counts the cycles to its return. A second hard case is that the open row is only visible through later candidates. The bench reaches it by walking a bank through precharge, activate to a new row and completion, and then confirming that a read to that row comes out as RD rather than PRE.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  typedef enum logic [2:0] {
    ST_PRECHARGED  = 3'd0,
    ST_ACTIVATED   = 3'd1,
    ST_PRECHARGING = 3'd2,
    ST_ACTIVATING  = 3'd3,
    ST_READING     = 3'd4,
    ST_WRITING     = 3'd5
  } bank_st_e;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_PRE = 3'd2,
    CMD_RD  = 3'd3,
    CMD_WR  = 3'd4
  } bank_cmd_e;

  // Settled states are the only ones in which a new command may be chosen.
  function automatic logic st_is_stable(bank_st_e s);
    return (s == ST_PRECHARGED) || (s == ST_ACTIVATED);
  endfunction

  function automatic logic st_returns_req(bank_st_e s);
    return (s == ST_READING) || (s == ST_WRITING);
  endfunction

  function automatic bank_cmd_e next_cmd(bank_st_e s, logic row_hit, logic is_wr);
    bank_cmd_e c;
    case (s)
      ST_PRECHARGED: c = CMD_ACT;
      ST_ACTIVATED:  c = !row_hit ? CMD_PRE : (is_wr ? CMD_WR : CMD_RD);
      default:       c = CMD_NOP;
    endcase
    return c;
  endfunction

  function automatic bank_st_e st_on_issue(bank_st_e s, bank_cmd_e c);
    bank_st_e n;
    case (c)
      CMD_ACT: n = ST_ACTIVATING;
      CMD_PRE: n = ST_PRECHARGING;
      CMD_RD:  n = ST_READING;
      CMD_WR:  n = ST_WRITING;
      default: n = s;
    endcase
    return n;
  endfunction

  function automatic bank_st_e st_on_done(bank_st_e s);
    bank_st_e n;
    case (s)
      ST_ACTIVATING:  n = ST_ACTIVATED;
      ST_PRECHARGING: n = ST_PRECHARGED;
      ST_READING:     n = ST_ACTIVATED;
      ST_WRITING:     n = ST_ACTIVATED;
      default:        n = s;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/bsm_req_hold.sv
module bsm_req_hold #(
  parameter int ROW_W = 14,
  parameter int ID_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_row,
  input  logic             req_write,
  input  logic [ID_W-1:0]  req_id,
  input  logic             rel_i,
  output logic             take_o,
  output logic             held_o,
  output logic [ROW_W-1:0] row_o,
  output logic             write_o,
  output logic [ID_W-1:0]  id_o
);

  logic             held_q;
  logic [ROW_W-1:0] row_q;
  logic             wr_q;
  logic [ID_W-1:0]  id_q;

  assign take_o  = !held_q && req_valid;
  assign held_o  = held_q;
  assign row_o   = row_q;
  assign write_o = wr_q;
  assign id_o    = id_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held_q <= 1'b0;
      row_q  <= '0;
      wr_q   <= 1'b0;
      id_q   <= '0;
    end else if (take_o) begin
      held_q <= 1'b1;
      row_q  <= req_row;
      wr_q   <= req_write;
      id_q   <= req_id;
    end else if (rel_i) begin
      held_q <= 1'b0;
    end
  end

endmodule

// File: rtl/bsm_sched.sv
module bsm_sched
  import bsm_pkg::*;
#(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             eval_i,
  input  logic             resched_i,
  input  logic             clear_i,
  input  logic [DLY_W-1:0] chk_delay,
  input  bank_cmd_e        cmd_i,
  output logic             armed_o,
  output logic             due_o,
  output bank_cmd_e        cmd_o
);

  localparam logic [DLY_W-1:0] FLOOR_FIRST = '0;
  localparam logic [DLY_W-1:0] FLOOR_AGAIN = DLY_W'(1);

  // Issue distance: the larger of the caller floor and the checker need.
  function automatic logic [DLY_W-1:0] wait_len(logic [DLY_W-1:0] floor_v,
                                                logic [DLY_W-1:0] need_v);
    return (need_v > floor_v) ? need_v : floor_v;
  endfunction

  logic             armed_q;
  logic [DLY_W-1:0] cnt_q;
  bank_cmd_e        cmd_q;

  assign armed_o = armed_q;
  assign due_o   = armed_q && (cnt_q == '0);
  assign cmd_o   = due_o ? cmd_q : CMD_NOP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
      cmd_q   <= CMD_NOP;
    end else if (clear_i) begin
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (resched_i) begin
      cnt_q   <= wait_len(FLOOR_AGAIN, chk_delay);
    end else if (eval_i) begin
      armed_q <= 1'b1;
      cnt_q   <= wait_len(FLOOR_FIRST, chk_delay);
      cmd_q   <= cmd_i;
    end else if (armed_q && (cnt_q != '0)) begin
      cnt_q   <= cnt_q - DLY_W'(1);
    end
  end

endmodule

// File: rtl/bsm_state.sv
module bsm_state
  import bsm_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int ID_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_i,
  input  logic             issue_i,
  input  bank_cmd_e        issue_cmd,
  input  logic [ROW_W-1:0] issue_row,
  input  logic [ID_W-1:0]  id_i,
  output bank_st_e         st_o,
  output logic [ROW_W-1:0] open_row_o,
  output logic             rel_o,
  output logic             bad_done_o,
  output logic             res_valid_o,
  output logic [ID_W-1:0]  res_id_o,
  output logic             err_o
);

  bank_st_e         st_q;
  logic [ROW_W-1:0] open_row_q;
  logic             res_valid_q;
  logic [ID_W-1:0]  res_id_q;
  logic             err_q;

  assign st_o        = st_q;
  assign open_row_o  = open_row_q;
  assign rel_o       = done_i && st_returns_req(st_q);
  assign bad_done_o  = done_i && st_is_stable(st_q);
  assign res_valid_o = res_valid_q;
  assign res_id_o    = res_id_q;
  assign err_o       = err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_PRECHARGED;
      open_row_q  <= '0;
      res_valid_q <= 1'b0;
      res_id_q    <= '0;
      err_q       <= 1'b0;
    end else begin
      if (issue_i) begin
        st_q <= st_on_issue(st_q, issue_cmd);
        if (issue_cmd == CMD_ACT) open_row_q <= issue_row;
      end else if (done_i) begin
        st_q <= st_on_done(st_q);
      end
      res_valid_q <= rel_o;
      if (rel_o) res_id_q <= id_i;
      if (bad_done_o) err_q <= 1'b1;
    end
  end

endmodule

// File: rtl/bank_cmd_fsm.sv
module bank_cmd_fsm
  import bsm_pkg::*;
#(
  parameter int ROW_W = 14,
  parameter int ID_W  = 8,
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ROW_W-1:0] req_row,
  input  logic             req_write,
  input  logic [ID_W-1:0]  req_id,
  output logic             req_take,
  input  logic [DLY_W-1:0] chk_delay,
  input  logic             grant,
  input  logic             cmd_sent,
  input  logic             done_pulse,
  output logic             cand_valid,
  output logic [2:0]       cand_cmd,
  output logic             result_valid,
  output logic [ID_W-1:0]  result_id,
  output logic             proto_err
);

  logic             held;
  logic [ROW_W-1:0] held_row;
  logic             held_wr;
  logic [ID_W-1:0]  held_id;
  logic             rel;
  logic             bad_done;
  bank_st_e         st_q;
  logic [ROW_W-1:0] open_row;
  logic             armed;
  logic             due;
  bank_cmd_e        cand_e;
  bank_cmd_e        want_cmd;
  logic             row_hit;
  logic             eval_ev;
  logic             issue_ev;
  logic             resched_ev;

  assign row_hit    = held && (held_row == open_row);
  assign want_cmd   = next_cmd(st_q, row_hit, held_wr);
  assign eval_ev    = st_is_stable(st_q) && held && !armed;
  assign issue_ev   = due && grant;
  assign resched_ev = due && cmd_sent && !grant;

  assign cand_valid = due;
  assign cand_cmd   = cand_e;

  bsm_req_hold #(.ROW_W(ROW_W), .ID_W(ID_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_row   (req_row),
    .req_write (req_write),
    .req_id    (req_id),
    .rel_i     (rel),
    .take_o    (req_take),
    .held_o    (held),
    .row_o     (held_row),
    .write_o   (held_wr),
    .id_o      (held_id)
  );

  bsm_sched #(.DLY_W(DLY_W)) u_sched (
    .clk       (clk),
    .rst_n     (rst_n),
    .eval_i    (eval_ev),
    .resched_i (resched_ev),
    .clear_i   (issue_ev),
    .chk_delay (chk_delay),
    .cmd_i     (want_cmd),
    .armed_o   (armed),
    .due_o     (due),
    .cmd_o     (cand_e)
  );

  bsm_state #(.ROW_W(ROW_W), .ID_W(ID_W)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .done_i      (done_pulse),
    .issue_i     (issue_ev),
    .issue_cmd   (cand_e),
    .issue_row   (held_row),
    .id_i        (held_id),
    .st_o        (st_q),
    .open_row_o  (open_row),
    .rel_o       (rel),
    .bad_done_o  (bad_done),
    .res_valid_o (result_valid),
    .res_id_o    (result_id),
    .err_o       (proto_err)
  );

endmodule

// File: rtl/bsm_chk.sv
module bsm_chk
  import bsm_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       grant,
  input logic       cmd_sent,
  input logic       done_pulse,
  input logic       req_take,
  input logic       cand_valid,
  input logic [2:0] cand_cmd,
  input logic       result_valid,
  input logic       proto_err,
  input bank_st_e   st
);

  // R2
  take_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_take |=> !req_take);

  // R3
  closed_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && st == ST_PRECHARGED) |-> cand_cmd == 3'd1);

  // R6
  grant_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && grant) |=> !cand_valid);

  // R6
  hold_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && !grant && !cmd_sent) |=> (cand_valid && $stable(cand_cmd)));

  // R7
  resched_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cand_valid && cmd_sent && !grant) |=> !cand_valid);

  // R8
  act_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && st == ST_ACTIVATING) |=> st == ST_ACTIVATED);

  // R9
  result_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> $past(done_pulse));

  // R10
  bad_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse && (st == ST_PRECHARGED || st == ST_ACTIVATED)) |=> proto_err);

  // R10
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);

endmodule

bind bank_cmd_fsm bsm_chk u_bsm_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .grant        (grant),
  .cmd_sent     (cmd_sent),
  .done_pulse   (done_pulse),
  .req_take     (req_take),
  .cand_valid   (cand_valid),
  .cand_cmd     (cand_cmd),
  .result_valid (result_valid),
  .proto_err    (proto_err),
  .st           (st_q)
);

// File: tb/bank_cmd_fsm_bench.sv
`timescale 1ns/1ps
module bank_cmd_fsm_bench;

  localparam int C_NOP = 0;
  localparam int C_ACT = 1;
  localparam int C_PRE = 2;
  localparam int C_RD  = 3;
  localparam int C_WR  = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [13:0] req_row = '0;
  logic        req_write = 1'b0;
  logic [7:0]  req_id = '0;
  logic        req_take;
  logic [5:0]  chk_delay = '0;
  logic        grant = 1'b0;
  logic        cmd_sent = 1'b0;
  logic        done_pulse = 1'b0;
  logic        cand_valid;
  logic [2:0]  cand_cmd;
  logic        result_valid;
  logic [7:0]  result_id;
  logic        proto_err;

  int checks = 0;
  int fails = 0;
  int exp_q[$];
  int mon_exp;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bank_cmd_fsm u_bank_cmd_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_row(req_row),
    .req_write(req_write), .req_id(req_id), .req_take(req_take),
    .chk_delay(chk_delay), .grant(grant), .cmd_sent(cmd_sent),
    .done_pulse(done_pulse), .cand_valid(cand_valid), .cand_cmd(cand_cmd),
    .result_valid(result_valid), .result_id(result_id), .proto_err(proto_err)
  );

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // Candidate seen at the port: NOP when not valid.
  task automatic check_cand(string tag, int exp_cmd);
    check({tag, " cand_valid"}, int'(cand_valid), (exp_cmd != C_NOP) ? 1 : 0);
    check({tag, " cand_cmd"}, int'(cand_cmd), exp_cmd);
  endtask

  task automatic expect_result(int id);
    exp_q.push_back(id);
  endtask

  // Offer one request; returns one edge later.
  task automatic fetch(int row, int wr, int id, int dly);
    req_valid = 1'b1;
    req_row   = 14'(row);
    req_write = wr[0];
    req_id    = 8'(id);
    chk_delay = 6'(dly);
    #1;
    check("R2 take while empty", int'(req_take), 1);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic pulse_grant();
    grant = 1'b1;
    step(1);
    grant = 1'b0;
  endtask

  task automatic pulse_done();
    done_pulse = 1'b1;
    step(1);
    done_pulse = 1'b0;
  endtask

  // Scoreboard monitor for completed requests.
  always @(negedge clk) begin
    if (rst_n && result_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R9 result: actual id %0d expected none", result_id);
      end else begin
        mon_exp = exp_q.pop_front();
        if (int'(result_id) != mon_exp) begin
          fails++;
          $display("FAIL R9 result: actual id %0d expected %0d", result_id, mon_exp);
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    check_cand("R1", C_NOP);
    check("R1 result_valid", int'(result_valid), 0);
    check("R1 proto_err", int'(proto_err), 0);
    check("R1 req_take", int'(req_take), 0);

    // Scenario A: closed bank, read row 5, checker delay 2
    fetch(5, 0, 3, 2);
    check_cand("R5 k1", C_NOP);
    step(1);
    check_cand("R5 k2", C_NOP);
    grant = 1'b1;                       // R11 stray grant, nothing visible
    step(1);
    grant = 1'b0;
    check_cand("R5 k3", C_NOP);
    step(1);
    check_cand("R3 R5 R11 act due", C_ACT);
    req_valid = 1'b1; req_row = 14'd77; req_id = 8'd99;
    #1;
    check("R2 no take while held", int'(req_take), 0);
    req_valid = 1'b0;
    step(2);
    check_cand("R6 act held", C_ACT);
    chk_delay = 6'd0;
    pulse_grant();
    check_cand("R6 cleared by grant", C_NOP);
    pulse_done();
    check_cand("R8 eval cycle", C_NOP);
    check("R8 no result", int'(result_valid), 0);
    step(1);
    check_cand("R3 R4 R8 row hit read", C_RD);
    pulse_grant();
    check_cand("R6 rd cleared", C_NOP);
    expect_result(3);
    pulse_done();
    check("R9 result_valid", int'(result_valid), 1);
    check("R9 result_id", int'(result_id), 3);
    step(1);
    check("R9 one cycle", int'(result_valid), 0);

    // Scenario B: write hit on open row 5, no delay
    fetch(5, 1, 7, 0);
    check_cand("R5 d0 k1", C_NOP);
    step(1);
    check_cand("R4 R5 write hit", C_WR);
    pulse_grant();
    expect_result(7);
    pulse_done();
    step(1);

    // Scenario C: row miss, withdrawal, full reopen to row 9
    fetch(9, 0, 1, 1);
    check_cand("R5 d1 k1", C_NOP);
    step(1);
    check_cand("R5 d1 k2", C_NOP);
    step(1);
    check_cand("R4 row miss", C_PRE);
    cmd_sent = 1'b1;
    chk_delay = 6'd2;
    step(1);
    cmd_sent = 1'b0;
    chk_delay = 6'd0;
    check_cand("R7 withdrawn", C_NOP);
    step(1);
    check_cand("R7 still waiting", C_NOP);
    step(1);
    check_cand("R7 back", C_PRE);
    pulse_grant();
    pulse_done();
    check_cand("R8 precharged eval", C_NOP);
    step(1);
    check_cand("R8 act after precharge", C_ACT);
    pulse_grant();
    pulse_done();
    step(1);
    check_cand("R3 new open row", C_RD);
    pulse_grant();
    expect_result(1);
    pulse_done();
    step(1);

    // Scenario D: completion while settled
    check("R10 before", int'(proto_err), 0);
    pulse_done();
    check("R10 raised", int'(proto_err), 1);
    check("R10 no result", int'(result_valid), 0);
    step(3);
    check("R10 sticky", int'(proto_err), 1);
    check_cand("R10 no cand", C_NOP);
    fetch(9, 0, 4, 0);
    step(1);
    check_cand("R10 state kept", C_RD);
    rst_n = 1'b0;
    step(1);
    rst_n = 1'b1;
    step(1);
    check("R1 err cleared", int'(proto_err), 0);
    check_cand("R1 after reset", C_NOP);

    check("R9 all results seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule